// File: doc/BRIEF.md
# Flash Unlock Command Sequence Decoder

This block sits behind the write path of a parallel NOR flash controller and watches the write bus one cycle at a time. Each accepted write cycle carries an address and a data word. Only the low 16 address bits and the low data byte are compared against the unlock keys and command codes. When a complete unlock-prefixed command sequence has been seen, the block issues a single-cycle pulse that names the operation. The pulse is accompanied by the address and data of the write that finished the sequence. The array, the embedded timers and the status readout are handled by neighbouring logic.

The commands are recognised by the cycle that follows the two-write unlock prefix. That cycle either completes a short command or opens the six-cycle extended form, and the last write of the extended form picks one of three commands. A few single-write commands are decoded directly from idle. Two sticky mode flags are held here:
- Single-pulse program mode, in which every write becomes a program.
- Product-ID mode, during which a small read mux returns identification bytes and the addressed sector's lock state.

An external busy input stops all decoding while an embedded program runs.

Top module: `flash_cmd_decoder`

## Requirements
- R1: A multi-cycle command starts with data 0xAA at address 0x5555 and then data 0x55 at address 0x2AAA. Only wr_addr_i[15:0] and wr_data_i[7:0] take part in matching.
- R2: After the prefix, a third write of 0xA0 at 0x5555 arms a program. The next write raises prog_o for one cycle, with cmd_addr_o and cmd_data_o equal to that write's full address and data. All command pulses appear in the cycle after the write that completes them.
- R3: After the prefix, the writes 0x80 at 0x5555, 0xAA at 0x5555 and 0x55 at 0x2AAA, followed by a sixth write of 0x30 at any address, raise erase_o with cmd_addr_o set to that sixth write's address.
- R4: The same five-write lead-in followed by a sixth write of 0x40 at any address raises lock_o with cmd_addr_o set to that address.
- R5: The same lead-in followed by 0xA0 at 0x5555 sets bypass_o. While bypass_o is set, every accepted write raises prog_o with its own address and data, including writes that would otherwise suspend, resume or start a sequence. Only rst_ni clears bypass_o.
- R6: After the prefix, a third write of 0x90 at 0x5555 pulses id_enter_o and sets id_mode_o.
- R7: id_exit_o pulses and id_mode_o clears on either of two events: the prefix followed by 0xF0 at 0x5555, or a single 0xF0 written to any address from idle.
- R8: From idle, a single write of 0xB0 to any address pulses suspend_o. From idle, a single write of 0x30 to any address pulses resume_o, with plane_o set to the top two address bits of that write.
- R9: A write that does not match the expected next cycle returns the decoder to idle without issuing a command. That write is consumed and is not taken as the start of a new sequence.
- R10: While busy_i is high, writes are ignored: no pulse is issued, and a partly entered sequence keeps its progress.
- R11: After reset, all pulses, bypass_o and id_mode_o are low. At most one command pulse is high in any cycle, and each pulse lasts one cycle.
- R12: While id_mode_o is set, id_data_o returns a value chosen by rd_off_i:
  - offset 0 returns 0x1F;
  - offset 1 returns DEV_CODE (default 0xC0);
  - offset 2 returns sec_lock_i on bit 0;
  - any other offset returns 0x00.

  Outside product-ID mode, id_data_o is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset; also leaves bypass mode |
| wr_en_i | input | 1 | One write cycle this clock |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | DATA_W | Write data |
| busy_i | input | 1 | Embedded program running; writes ignored |
| rd_off_i | input | OFF_W | Read offset within the addressed sector |
| sec_lock_i | input | 1 | Lock state of the sector being read |
| prog_o | output | 1 | Program pulse |
| erase_o | output | 1 | Sector erase pulse |
| lock_o | output | 1 | Sector lockout enable pulse |
| id_enter_o | output | 1 | Product-ID entry pulse |
| id_exit_o | output | 1 | Product-ID exit pulse |
| suspend_o | output | 1 | Erase suspend pulse |
| resume_o | output | 1 | Erase resume pulse |
| plane_o | output | PLANE_W | Plane selected by the last resume |
| cmd_addr_o | output | ADDR_W | Address of the write that completed the last command |
| cmd_data_o | output | DATA_W | Data of the write that completed the last command |
| bypass_o | output | 1 | Single-pulse program mode active |
| id_mode_o | output | 1 | Product-ID mode active |
| id_data_o | output | 8 | Identification read data |

## Verification
The bench sweeps every data byte at three branch points:
- the sixth cycle of the extended form;
- the third cycle after the prefix;
- a lone write from idle.

Each sweep catches a decoder that confuses 0x30, 0x40, 0xA0, 0x90, 0xF0 or 0xB0 across states, or that accepts 0xA0 at a sector address as a bypass unlock.

The upper address and data bits carry junk, which exposes a design that compares the full bus. A broken prefix followed by a well-formed tail shows whether the mismatching write is wrongly reused as a new first cycle.

Bypass mode is stressed with command-like data. A design that still decodes suspend, resume or the unlock prefix would pulse the wrong output there, and one that drops bypass without a reset would stop programming. The busy window is opened in the middle of a sequence, to show that progress is kept and nothing fires.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam int MATCH_AW = 16;
  localparam int MATCH_DW = 8;
  localparam int NCODE    = 9;
  localparam int NPULSE   = 7;

  localparam logic [MATCH_AW-1:0] ADDR_KEY1 = 16'h5555;
  localparam logic [MATCH_AW-1:0] ADDR_KEY2 = 16'h2AAA;

  typedef enum logic [3:0] {
    C_AA = 4'd0, C_55 = 4'd1, C_A0 = 4'd2, C_80 = 4'd3, C_90 = 4'd4,
    C_F0 = 4'd5, C_B0 = 4'd6, C_30 = 4'd7, C_40 = 4'd8
  } code_e;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_K1, SQ_K2, SQ_PGM, SQ_E3, SQ_E4, SQ_E5
  } seq_e;

  // pulse index = value - 1 for the first NPULSE entries
  typedef enum logic [3:0] {
    CMD_NONE     = 4'd0,
    CMD_PROG     = 4'd1,
    CMD_ERASE    = 4'd2,
    CMD_LOCK     = 4'd3,
    CMD_ID_ENTER = 4'd4,
    CMD_ID_EXIT  = 4'd5,
    CMD_SUSPEND  = 4'd6,
    CMD_RESUME   = 4'd7,
    CMD_BYPASS   = 4'd8
  } cmd_e;

  typedef struct packed {
    logic             at_k1;
    logic             at_k2;
    logic [NCODE-1:0] code;
  } match_t;

  function automatic logic [MATCH_DW-1:0] code_val(input int idx);
    case (idx)
      0:       return 8'hAA;
      1:       return 8'h55;
      2:       return 8'hA0;
      3:       return 8'h80;
      4:       return 8'h90;
      5:       return 8'hF0;
      6:       return 8'hB0;
      7:       return 8'h30;
      8:       return 8'h40;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/flash_cmd_match.sv
module flash_cmd_match
  import flash_cmd_pkg::*;
(
  input  logic [MATCH_AW-1:0] addr_i,
  input  logic [MATCH_DW-1:0] data_i,
  output match_t              match_o
);

  logic [NCODE-1:0] hit;

  for (genvar g = 0; g < NCODE; g++) begin : g_code
    assign hit[g] = (data_i == code_val(g));
  end

  always_comb begin
    match_o.at_k1 = (addr_i == ADDR_KEY1);
    match_o.at_k2 = (addr_i == ADDR_KEY2);
    match_o.code  = hit;
  end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   valid_i,
  input  logic   bypass_i,
  input  match_t match_i,
  output cmd_e   cmd_o
);

  seq_e st_q, st_d;

  always_comb begin
    st_d  = st_q;
    cmd_o = CMD_NONE;
    if (valid_i) begin
      if (bypass_i) begin
        cmd_o = CMD_PROG;
        st_d  = SQ_IDLE;
      end else begin
        unique case (st_q)
          SQ_IDLE: begin
            if (match_i.at_k1 && match_i.code[C_AA]) st_d = SQ_K1;
            else if (match_i.code[C_F0])             cmd_o = CMD_ID_EXIT;
            else if (match_i.code[C_B0])             cmd_o = CMD_SUSPEND;
            else if (match_i.code[C_30])             cmd_o = CMD_RESUME;
          end
          SQ_K1: st_d = (match_i.at_k2 && match_i.code[C_55]) ? SQ_K2 : SQ_IDLE;
          SQ_K2: begin
            st_d = SQ_IDLE;
            if (match_i.at_k1) begin
              if (match_i.code[C_A0])      st_d  = SQ_PGM;
              else if (match_i.code[C_80]) st_d  = SQ_E3;
              else if (match_i.code[C_90]) cmd_o = CMD_ID_ENTER;
              else if (match_i.code[C_F0]) cmd_o = CMD_ID_EXIT;
            end
          end
          SQ_PGM: begin
            cmd_o = CMD_PROG;
            st_d  = SQ_IDLE;
          end
          SQ_E3: st_d = (match_i.at_k1 && match_i.code[C_AA]) ? SQ_E4 : SQ_IDLE;
          SQ_E4: st_d = (match_i.at_k2 && match_i.code[C_55]) ? SQ_E5 : SQ_IDLE;
          SQ_E5: begin
            st_d = SQ_IDLE;
            if (match_i.code[C_30])                      cmd_o = CMD_ERASE;
            else if (match_i.code[C_40])                 cmd_o = CMD_LOCK;
            else if (match_i.at_k1 && match_i.code[C_A0]) cmd_o = CMD_BYPASS;
          end
          default: st_d = SQ_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= SQ_IDLE;
    else         st_q <= st_d;
  end

endmodule

// File: rtl/flash_cmd_issue.sv
module flash_cmd_issue
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int DATA_W  = 16,
  parameter int PLANE_W = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  cmd_e               cmd_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  data_i,
  output logic [NPULSE-1:0]  pulse_o,
  output logic [PLANE_W-1:0] plane_o,
  output logic [ADDR_W-1:0]  cmd_addr_o,
  output logic [DATA_W-1:0]  cmd_data_o,
  output logic               bypass_o,
  output logic               id_mode_o
);

  for (genvar g = 0; g < NPULSE; g++) begin : g_pulse
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pulse_o[g] <= 1'b0;
      else         pulse_o[g] <= (cmd_i == cmd_e'(g + 1));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      plane_o    <= '0;
      cmd_addr_o <= '0;
      cmd_data_o <= '0;
      bypass_o   <= 1'b0;
      id_mode_o  <= 1'b0;
    end else begin
      if (cmd_i != CMD_NONE) begin
        cmd_addr_o <= addr_i;
        cmd_data_o <= data_i;
      end
      if (cmd_i == CMD_RESUME) plane_o <= addr_i[ADDR_W-1 -: PLANE_W];
      if (cmd_i == CMD_BYPASS) bypass_o <= 1'b1;
      if (cmd_i == CMD_ID_ENTER)     id_mode_o <= 1'b1;
      else if (cmd_i == CMD_ID_EXIT) id_mode_o <= 1'b0;
    end
  end

endmodule

// File: rtl/flash_id_read.sv
module flash_id_read #(
  parameter int          OFF_W       = 12,
  parameter logic [7:0]  VENDOR_CODE = 8'h1F,
  parameter logic [7:0]  DEV_CODE    = 8'hC0
) (
  input  logic             id_mode_i,
  input  logic [OFF_W-1:0] rd_off_i,
  input  logic             sec_lock_i,
  output logic [7:0]       id_data_o
);

  always_comb begin
    id_data_o = 8'h00;
    if (id_mode_i) begin
      if (rd_off_i == OFF_W'(0))      id_data_o = VENDOR_CODE;
      else if (rd_off_i == OFF_W'(1)) id_data_o = DEV_CODE;
      else if (rd_off_i == OFF_W'(2)) id_data_o = {7'b0, sec_lock_i};
    end
  end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int         ADDR_W   = 20,
  parameter int         DATA_W   = 16,
  parameter int         OFF_W    = 12,
  parameter int         PLANE_W  = 2,
  parameter logic [7:0] DEV_CODE = 8'hC0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic               busy_i,
  input  logic [OFF_W-1:0]   rd_off_i,
  input  logic               sec_lock_i,
  output logic               prog_o,
  output logic               erase_o,
  output logic               lock_o,
  output logic               id_enter_o,
  output logic               id_exit_o,
  output logic               suspend_o,
  output logic               resume_o,
  output logic [PLANE_W-1:0] plane_o,
  output logic [ADDR_W-1:0]  cmd_addr_o,
  output logic [DATA_W-1:0]  cmd_data_o,
  output logic               bypass_o,
  output logic               id_mode_o,
  output logic [7:0]         id_data_o
);

  match_t              match;
  cmd_e                cmd;
  logic                valid;
  logic [NPULSE-1:0]   pulse;

  assign valid = wr_en_i & ~busy_i;

  flash_cmd_match u_match (
    .addr_i  (wr_addr_i[MATCH_AW-1:0]),
    .data_i  (wr_data_i[MATCH_DW-1:0]),
    .match_o (match)
  );

  flash_cmd_seq u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (valid),
    .bypass_i (bypass_o),
    .match_i  (match),
    .cmd_o    (cmd)
  );

  flash_cmd_issue #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .PLANE_W (PLANE_W)
  ) u_issue (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_i      (cmd),
    .addr_i     (wr_addr_i),
    .data_i     (wr_data_i),
    .pulse_o    (pulse),
    .plane_o    (plane_o),
    .cmd_addr_o (cmd_addr_o),
    .cmd_data_o (cmd_data_o),
    .bypass_o   (bypass_o),
    .id_mode_o  (id_mode_o)
  );

  flash_id_read #(
    .OFF_W    (OFF_W),
    .DEV_CODE (DEV_CODE)
  ) u_id (
    .id_mode_i  (id_mode_o),
    .rd_off_i   (rd_off_i),
    .sec_lock_i (sec_lock_i),
    .id_data_o  (id_data_o)
  );

  assign prog_o     = pulse[CMD_PROG - 1];
  assign erase_o    = pulse[CMD_ERASE - 1];
  assign lock_o     = pulse[CMD_LOCK - 1];
  assign id_enter_o = pulse[CMD_ID_ENTER - 1];
  assign id_exit_o  = pulse[CMD_ID_EXIT - 1];
  assign suspend_o  = pulse[CMD_SUSPEND - 1];
  assign resume_o   = pulse[CMD_RESUME - 1];

endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk #(
  parameter int ADDR_W  = 20,
  parameter int DATA_W  = 16,
  parameter int OFF_W   = 12,
  parameter int PLANE_W = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_en_i,
  input logic [ADDR_W-1:0]  wr_addr_i,
  input logic [DATA_W-1:0]  wr_data_i,
  input logic               busy_i,
  input logic [OFF_W-1:0]   rd_off_i,
  input logic               prog_o,
  input logic               erase_o,
  input logic               lock_o,
  input logic               id_enter_o,
  input logic               id_exit_o,
  input logic               suspend_o,
  input logic               resume_o,
  input logic [PLANE_W-1:0] plane_o,
  input logic [ADDR_W-1:0]  cmd_addr_o,
  input logic [DATA_W-1:0]  cmd_data_o,
  input logic               bypass_o,
  input logic               id_mode_o,
  input logic [7:0]         id_data_o
);

  logic [6:0] pulses;
  assign pulses = {prog_o, erase_o, lock_o, id_enter_o, id_exit_o, suspend_o, resume_o};

  assert_one_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pulses));

  assert_no_write_no_cmd_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> pulses == 7'd0);

  assert_busy_ignored_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> pulses == 7'd0);

  assert_bypass_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bypass_o |=> bypass_o);

  assert_bypass_prog_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bypass_o && wr_en_i && !busy_i) |=>
      (prog_o && cmd_addr_o == $past(wr_addr_i) && cmd_data_o == $past(wr_data_i)));

  assert_id_enter_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    id_enter_o |-> id_mode_o);

  assert_id_exit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    id_exit_o |-> !id_mode_o);

  assert_suspend_code_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    suspend_o |-> $past(wr_data_i[7:0]) == 8'hB0);

  assert_resume_plane_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_o |-> (plane_o == $past(wr_addr_i[ADDR_W-1 -: PLANE_W]) &&
                  $past(wr_data_i[7:0]) == 8'h30));

  assert_id_vendor_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_mode_o && rd_off_i == OFF_W'(0)) |-> id_data_o == 8'h1F);

  assert_id_quiet_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !id_mode_o |-> id_data_o == 8'h00);

endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .OFF_W   (OFF_W),
  .PLANE_W (PLANE_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .wr_addr_i  (wr_addr_i),
  .wr_data_i  (wr_data_i),
  .busy_i     (busy_i),
  .rd_off_i   (rd_off_i),
  .prog_o     (prog_o),
  .erase_o    (erase_o),
  .lock_o     (lock_o),
  .id_enter_o (id_enter_o),
  .id_exit_o  (id_exit_o),
  .suspend_o  (suspend_o),
  .resume_o   (resume_o),
  .plane_o    (plane_o),
  .cmd_addr_o (cmd_addr_o),
  .cmd_data_o (cmd_data_o),
  .bypass_o   (bypass_o),
  .id_mode_o  (id_mode_o),
  .id_data_o  (id_data_o)
);

// File: tb/flash_cmd_decoder_test.sv
`timescale 1ns/1ps
module flash_cmd_decoder_test;
  localparam int AW = 20;
  localparam int DW = 16;
  localparam int OW = 12;

  localparam logic [6:0] E_NONE  = 7'b0000000;
  localparam logic [6:0] E_PROG  = 7'b1000000;
  localparam logic [6:0] E_ERASE = 7'b0100000;
  localparam logic [6:0] E_LOCK  = 7'b0010000;
  localparam logic [6:0] E_IDIN  = 7'b0001000;
  localparam logic [6:0] E_IDOUT = 7'b0000100;
  localparam logic [6:0] E_SUSP  = 7'b0000010;
  localparam logic [6:0] E_RES   = 7'b0000001;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          busy = 1'b0;
  logic [OW-1:0] rd_off = '0;
  logic          sec_lock = 1'b0;
  logic prog_o, erase_o, lock_o, id_enter_o, id_exit_o, suspend_o, resume_o;
  logic [1:0]    plane_o;
  logic [AW-1:0] cmd_addr_o;
  logic [DW-1:0] cmd_data_o;
  logic          bypass_o, id_mode_o;
  logic [7:0]    id_data_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  flash_cmd_decoder uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .busy_i(busy), .rd_off_i(rd_off), .sec_lock_i(sec_lock),
    .prog_o(prog_o), .erase_o(erase_o), .lock_o(lock_o), .id_enter_o(id_enter_o),
    .id_exit_o(id_exit_o), .suspend_o(suspend_o), .resume_o(resume_o),
    .plane_o(plane_o), .cmd_addr_o(cmd_addr_o), .cmd_data_o(cmd_data_o),
    .bypass_o(bypass_o), .id_mode_o(id_mode_o), .id_data_o(id_data_o)
  );

  wire [6:0] pulses = {prog_o, erase_o, lock_o, id_enter_o, id_exit_o, suspend_o, resume_o};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive at a falling edge, sampled at the rising edge, result visible at the next falling edge
  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic prefix();
    wr(20'hF5555, 16'h12AA);
    wr(20'h32AAA, 16'hEE55);
  endtask

  task automatic ext_lead();
    prefix();
    wr(20'h05555, 16'h0080);
    wr(20'h05555, 16'h00AA);
    wr(20'h02AAA, 16'h0055);
  endtask

  task automatic do_reset();
    wr_en = 1'b0; busy = 1'b0; rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [6:0] exp;
    bit idm;
    do_reset();

    // R11 reset state
    check("R11 reset pulses", pulses, E_NONE);
    check("R11 reset bypass", bypass_o, 0);
    check("R11 reset id_mode", id_mode_o, 0);
    check("R12 id_data outside id mode", id_data_o, 8'h00);

    // R3 R4 R9 R1: sweep the sixth-cycle data byte
    for (int d = 0; d < 256; d++) begin
      ext_lead();
      wr(20'h47123, {8'h5A, 8'(d)});
      exp = (d == 8'h30) ? E_ERASE : (d == 8'h40) ? E_LOCK : E_NONE;
      check($sformatf("R3_R4_R9 sixth cycle d=%0h", d), pulses, exp);
      if (exp != E_NONE) check("R3_R4 sector address", cmd_addr_o, 20'h47123);
      check("R5 no bypass at sector address", bypass_o, 0);
    end

    // R6 R7 R2 R9 R1: sweep the third-cycle data byte
    idm = 1'b0;
    for (int d = 0; d < 256; d++) begin
      prefix();
      wr(20'hA5555, {8'hFF, 8'(d)});
      exp = E_NONE;
      if (d == 8'h90) begin exp = E_IDIN; idm = 1'b1; end
      if (d == 8'hF0) begin exp = E_IDOUT; idm = 1'b0; end
      check($sformatf("R1_R6_R7 third cycle d=%0h", d), pulses, exp);
      check("R6_R7 id_mode", id_mode_o, idm);
      if (d == 8'hA0) begin
        wr(20'h30F0F, 16'hBEEF);
        check("R2 program pulse", pulses, E_PROG);
        check("R2 program address", cmd_addr_o, 20'h30F0F);
        check("R2 program data", cmd_data_o, 16'hBEEF);
        @(negedge clk);
        check("R11 pulse one cycle", pulses, E_NONE);
      end
      if (d == 8'h80) begin
        wr(20'h00000, 16'h0000);
        check("R9 abort at fourth cycle", pulses, E_NONE);
      end
    end

    // R8 R7: single-write sweep from idle
    for (int d = 0; d < 256; d++) begin
      wr({2'(d), 18'h01234}, {8'hC3, 8'(d)});
      exp = (d == 8'hB0) ? E_SUSP : (d == 8'h30) ? E_RES : (d == 8'hF0) ? E_IDOUT : E_NONE;
      check($sformatf("R8_R7 single write d=%0h", d), pulses, exp);
      if (d == 8'h30) check("R8 resume plane", plane_o, 2'(d));
    end
    wr(20'hC1234, 16'h0030);
    check("R8 resume plane 3", plane_o, 2'd3);

    // R9 mismatching write is consumed
    wr(20'h05555, 16'h00AA);
    wr(20'h05555, 16'h00AA);
    wr(20'h02AAA, 16'h0055);
    wr(20'h05555, 16'h00A0);
    wr(20'h11111, 16'h0012);
    check("R9 broken prefix yields nothing", pulses, E_NONE);

    // R10 busy mid-sequence
    prefix();
    busy = 1'b1;
    wr(20'h00000, 16'h00B0);
    check("R10 busy write ignored", pulses, E_NONE);
    busy = 1'b0;
    wr(20'h05555, 16'h00A0);
    wr(20'h22222, 16'h1234);
    check("R10 sequence kept across busy", pulses, E_PROG);

    // R12 product-ID reads
    prefix();
    wr(20'h05555, 16'h0090);
    for (int o = 0; o < 4; o++) begin
      for (int lk = 0; lk < 2; lk++) begin
        rd_off = OW'(o); sec_lock = 1'(lk);
        #1;
        check($sformatf("R12 id read off=%0d lk=%0d", o, lk), id_data_o,
              (o == 0) ? 8'h1F : (o == 1) ? 8'hC0 : (o == 2) ? 8'(lk) : 8'h00);
      end
    end
    rd_off = 12'hFFF; #1;
    check("R12 id read far offset", id_data_o, 8'h00);
    rd_off = '0;
    @(negedge clk);
    wr(20'h9ABCD, 16'h00F0);
    check("R7 single-write exit", id_mode_o, 0);
    check("R12 id data after exit", id_data_o, 8'h00);

    // R5 bypass mode
    ext_lead();
    wr(20'h05555, 16'h00A0);
    check("R5 bypass set", bypass_o, 1);
    check("R5 unlock issues no pulse", pulses, E_NONE);
    wr(20'h05555, 16'h00AA);
    check("R5 AA programs", pulses, E_PROG);
    check("R5 AA program address", cmd_addr_o, 20'h05555);
    wr(20'h80000, 16'h00B0);
    check("R5 B0 programs", pulses, E_PROG);
    wr(20'hC0000, 16'h7730);
    check("R5 30 programs", pulses, E_PROG);
    check("R5 30 program data", cmd_data_o, 16'h7730);
    busy = 1'b1;
    wr(20'h00001, 16'h0001);
    check("R10 busy in bypass", pulses, E_NONE);
    busy = 1'b0;
    @(negedge clk);
    check("R5 bypass still set", bypass_o, 1);
    do_reset();
    check("R5 reset clears bypass", bypass_o, 0);
    wr(20'h80000, 16'h00B0);
    check("R5 suspend decoded after reset", pulses, E_SUSP);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule